// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of an asynchronous serial port. It has a holding register in front of a shift register, so software can queue the next character while the current one is still on the line. A bit-rate tick, generated elsewhere, advances the line by one bit per tick. Each character goes out as one start bit (0), the data bits least significant first, an optional ninth bit, and one stop bit (1). Between characters the line rests at 1.

Two readiness flags serve different purposes:

- **Holding-empty flag.** It reports that the holding register can accept another character. Its interrupt request stays asserted for as long as the flag is set and its enable is on.
- **Line-done flag.** It reports that the last frame has fully left the line and nothing is queued. A half-duplex application uses it to release the bus. It is cleared by a write-one strobe or by the acknowledge of its interrupt.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset the holding-empty flag is 1, the line-done flag is 0, both interrupt requests are 0 and the line is 1. The control register resets to zero, so the transmitter is off and both interrupt enables are off.
- R2: A data write clears the holding-empty flag. The flag becomes 1 again on the cycle after the queued character is moved into the shift register.
- R3: Control encoding: ctrlIn[0] is transmit enable. Transmission works as follows:
  - On the first tick where the transmitter is enabled and a character is queued, the character is moved into the shift register and the line drops to 0 (start bit).
  - Each following tick puts the next data bit on the line, least significant first.
  - After the data bits comes a stop bit of 1.
  - The line is 1 when idle.
- R4: ctrlIn[1] selects nine-bit mode. In that mode ctrlIn[2] is sent as the ninth data bit, after the low DATA_W bits and before the stop bit. Its value is captured when the character moves into the shift register; later control writes do not change the frame in flight.
- R5: The tick that ends the stop bit sets the line-done flag only if nothing is queued. If a character is queued at that tick, the line drops straight to its start bit, with no idle bit between frames, and the line-done flag stays 0.
- R6: The line-done flag is cleared by irqAck or by doneClr. If a set and a clear fall on the same cycle, the flag is set.
- R7: The interrupt requests are these combinations, held for as long as they are true:
  - irqEmpty = holding-empty flag AND ctrlIn[3].
  - irqDone = line-done flag AND ctrlIn[4].
- R8: While transmit enable is 0, no frame starts and the line is 1, and a queued character stays queued. Clearing the enable during a frame abandons that frame: the line returns to 1 and the line-done flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle bit-rate pulse; one line bit per tick |
| dataWr | input | 1 | Write strobe for the holding register |
| dataIn | input | DATA_W | Character to queue |
| ctrlWr | input | 1 | Write strobe for the control register |
| ctrlIn | input | 5 | Control value: [0] enable, [1] nine-bit mode, [2] ninth bit, [3] empty interrupt enable, [4] done interrupt enable |
| doneClr | input | 1 | Write-one clear of the line-done flag |
| irqAck | input | 1 | Acknowledge of the line-done interrupt |
| txd | output | 1 | Serial line |
| dataEmpty | output | 1 | Holding-empty flag |
| txDone | output | 1 | Line-done flag |
| irqEmpty | output | 1 | Holding-empty interrupt request |
| irqDone | output | 1 | Line-done interrupt request |

## Verification
The bench builds the block with DATA_W = 4. This makes an exhaustive sweep practical: every character value is sent in eight-bit-style mode, and again in nine-bit mode with both values of the ninth bit. Every line bit of every frame is compared with the bit worked out from the character value. The small frame also makes the directed cases short:
- back-to-back frames,
- a set colliding with a clear of the line-done flag,
- a frame abandoned when the enable is cleared.

// File: rtl/dbuf_uart_tx_pkg.sv
package dbuf_uart_tx_pkg;
  // control register field positions
  localparam int CtlTxOn    = 0;
  localparam int CtlWide    = 1;
  localparam int CtlExtra   = 2;
  localparam int CtlEmptyIe = 3;
  localparam int CtlDoneIe  = 4;
  localparam int CtlW       = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // move holding register into shift register, drive start bit
    logic shift;  // put next shift bit on the line
    logic park;   // force line idle (transmitter off)
  } txStrobe_t;
endpackage

// File: rtl/dbuf_uart_tx_dp.sv
module dbuf_uart_tx_dp
  import dbuf_uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              wide,
  input  logic              extraBit,
  output logic              txd
);
  localparam int SH_W = DATA_W + 2;

  logic [DATA_W-1:0] holdQ;
  logic [SH_W-1:0]   shQ;
  logic              txdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdQ <= '0;
    else if (dataWr) holdQ <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shQ  <= '1;
      txdQ <= 1'b1;
    end else if (strobe.park) begin
      txdQ <= 1'b1;
    end else if (strobe.load) begin
      // ninth bit captured here; in short mode that slot carries the stop level
      shQ  <= {1'b1, (wide ? extraBit : 1'b1), holdQ};
      txdQ <= 1'b0;
    end else if (strobe.shift) begin
      txdQ <= shQ[0];
      shQ  <= {1'b1, shQ[SH_W-1:1]};
    end
  end

  assign txd = txdQ;
endmodule

// File: rtl/dbuf_uart_tx_ctl.sv
module dbuf_uart_tx_ctl
  import dbuf_uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic            dataWr,
  input  logic            ctrlWr,
  input  logic [CtlW-1:0] ctrlIn,
  input  logic            doneClr,
  input  logic            irqAck,
  output txStrobe_t       strobe,
  output logic            wide,
  output logic            extraBit,
  output logic            txOnQ,
  output logic            dataEmpty,
  output logic            txDone,
  output logic            irqEmpty,
  output logic            irqDone
);
  localparam int CNT_W  = $clog2(DATA_W + 3);
  localparam int N_BASE = DATA_W + 1;   // data bits plus stop bit

  logic [CtlW-1:0]  ctrlQ;
  logic             busyQ, emptyQ, doneQ;
  logic [CNT_W-1:0] cntQ;
  logic             lastBit, frameEnd, canLoad, setDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else if (ctrlWr) ctrlQ <= ctrlIn;
  end

  assign txOnQ    = ctrlQ[CtlTxOn];
  assign wide     = ctrlQ[CtlWide];
  assign extraBit = ctrlQ[CtlExtra];

  assign lastBit  = (cntQ == '0);
  assign frameEnd = txOnQ && busyQ && lastBit && tick;
  assign canLoad  = txOnQ && !emptyQ && tick && (!busyQ || lastBit);
  assign setDone  = frameEnd && emptyQ;

  always_comb begin
    strobe       = '0;
    strobe.park  = !txOnQ;
    strobe.load  = canLoad;
    strobe.shift = txOnQ && busyQ && tick && !lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (!txOnQ) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (canLoad) begin
      busyQ <= 1'b1;
      cntQ  <= CNT_W'(N_BASE) + CNT_W'(wide);
    end else if (frameEnd) begin
      busyQ <= 1'b0;
    end else if (strobe.shift) begin
      cntQ  <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) emptyQ <= 1'b1;
    else if (dataWr) emptyQ <= 1'b0;
    else if (canLoad) emptyQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else if (setDone) doneQ <= 1'b1;
    else if (irqAck || doneClr) doneQ <= 1'b0;
  end

  assign dataEmpty = emptyQ;
  assign txDone    = doneQ;
  assign irqEmpty  = emptyQ && ctrlQ[CtlEmptyIe];
  assign irqDone   = doneQ && ctrlQ[CtlDoneIe];
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
  import dbuf_uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ctrlWr,
  input  logic [4:0]        ctrlIn,
  input  logic              doneClr,
  input  logic              irqAck,
  output logic              txd,
  output logic              dataEmpty,
  output logic              txDone,
  output logic              irqEmpty,
  output logic              irqDone
);
  txStrobe_t strobe;
  logic      wide, extraBit, txOnQ;

  dbuf_uart_tx_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .tick(tick), .dataWr(dataWr),
    .ctrlWr(ctrlWr), .ctrlIn(ctrlIn), .doneClr(doneClr), .irqAck(irqAck),
    .strobe(strobe), .wide(wide), .extraBit(extraBit), .txOnQ(txOnQ),
    .dataEmpty(dataEmpty), .txDone(txDone),
    .irqEmpty(irqEmpty), .irqDone(irqDone)
  );

  dbuf_uart_tx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataWr(dataWr),
    .dataIn(dataIn), .wide(wide), .extraBit(extraBit), .txd(txd)
  );
endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic dataWr,
  input logic ctrlWr,
  input logic doneClr,
  input logic irqAck,
  input logic txd,
  input logic dataEmpty,
  input logic txDone,
  input logic irqEmpty,
  input logic irqDone,
  input logic txOnQ
);
  p_write_fills_r2: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> !dataEmpty);

  p_start_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txd) |-> $past(tick));

  p_done_on_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDone) |-> $past(tick));

  p_done_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txDone) |-> $past(irqAck || doneClr));

  p_irq_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqEmpty |-> dataEmpty);

  p_irq_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqDone |-> txDone);

  p_off_line_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(!txOnQ) |-> txd);

  p_off_no_change_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!txOnQ) && !$past(ctrlWr)) |-> $stable(txDone) || $past(irqAck || doneClr));
endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .dataWr(dataWr), .ctrlWr(ctrlWr),
  .doneClr(doneClr), .irqAck(irqAck), .txd(txd), .dataEmpty(dataEmpty),
  .txDone(txDone), .irqEmpty(irqEmpty), .irqDone(irqDone), .txOnQ(txOnQ)
);

// File: tb/dbuf_uart_tx_test.sv
module dbuf_uart_tx_test;
  localparam int DW = 4;

  logic          clk = 0, rstN = 0, tick = 0, dataWr = 0, ctrlWr = 0;
  logic          doneClr = 0, irqAck = 0;
  logic [DW-1:0] dataIn = '0;
  logic [4:0]    ctrlIn = '0;
  logic          txd, dataEmpty, txDone, irqEmpty, irqDone;
  int            checks = 0, errors = 0;
  bit            finished = 0;

  always #5 clk = ~clk;

  dbuf_uart_tx #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .dataWr(dataWr), .dataIn(dataIn),
    .ctrlWr(ctrlWr), .ctrlIn(ctrlIn), .doneClr(doneClr), .irqAck(irqAck),
    .txd(txd), .dataEmpty(dataEmpty), .txDone(txDone),
    .irqEmpty(irqEmpty), .irqDone(irqDone)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // each task drives after a falling edge and returns at the next falling edge
  task automatic doTick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic writeData(logic [DW-1:0] v);
    @(negedge clk) begin dataWr = 1; dataIn = v; end
    @(negedge clk) dataWr = 0;
  endtask

  task automatic writeCtrl(logic [4:0] v);
    @(negedge clk) begin ctrlWr = 1; ctrlIn = v; end
    @(negedge clk) ctrlWr = 0;
  endtask

  task automatic clearDone(bit viaAck);
    @(negedge clk) begin irqAck = viaAck; doneClr = !viaAck; end
    @(negedge clk) begin irqAck = 0; doneClr = 0; end
  endtask

  // ctrl: [0] on [1] wide [2] ninth [3] emptyIe [4] doneIe
  task automatic sendChar(logic [DW-1:0] v, bit wide, bit b9);
    logic [4:0] c;
    c = {1'b1, 1'b1, b9, wide, 1'b1};
    writeCtrl(c);
    writeData(v);
    check("R2 empty cleared by write", dataEmpty, 0);
    check("R7 irqEmpty low while full", irqEmpty, 0);
    doTick();
    check("R3 start bit", txd, 0);
    check("R2 empty set on transfer", dataEmpty, 1);
    check("R7 irqEmpty follows flag", irqEmpty, 1);
    writeCtrl({1'b1, 1'b1, !b9, wide, 1'b1});  // R4: must not alter frame
    for (int i = 0; i < DW + int'(wide); i++) begin
      doTick();
      if (i < DW) check("R3 data bit", txd, int'(v[i]));
      else        check("R4 ninth bit latched", txd, int'(b9));
    end
    doTick();
    check("R3 stop bit", txd, 1);
    check("R5 done not yet", txDone, 0);
    doTick();
    check("R5 done after stop", txDone, 1);
    check("R7 irqDone follows flag", irqDone, 1);
    check("R3 idle high", txd, 1);
    clearDone(v[0]);
    check("R6 done cleared", txDone, 0);
    check("R7 irqDone cleared", irqDone, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 empty at reset", dataEmpty, 1);
    check("R1 done at reset", txDone, 0);
    check("R1 irqEmpty at reset", irqEmpty, 0);
    check("R1 irqDone at reset", irqDone, 0);
    check("R1 line at reset", txd, 1);

    // R1/R8: control reset to zero, transmitter off
    writeData(4'hA);
    repeat (3) begin
      doTick();
      check("R8 line held while off", txd, 1);
    end
    check("R8 char stays queued", dataEmpty, 0);

    // enable: queued char sends; then abandon mid frame
    writeCtrl(5'b00001);
    doTick();
    check("R3 start after enable", txd, 0);
    doTick();
    check("R3 bit0 of A", txd, 0);
    doTick();
    check("R3 bit1 of A", txd, 1);
    writeCtrl(5'b00000);
    check("R8 abort line high", txd, 1);
    repeat (DW + 2) doTick();
    check("R8 abort no done", txDone, 0);
    check("R8 abort line stays high", txd, 1);

    // exhaustive sweep
    for (int w = 0; w < 2; w++)
      for (int v = 0; v < (1 << DW); v++)
        for (int b = 0; b <= w; b++)
          sendChar(DW'(v), w[0], b[0]);

    // back-to-back frames (R5)
    writeCtrl(5'b00001);
    writeData(4'h5);
    doTick();
    check("R3 start of first", txd, 0);
    writeData(4'h3);
    check("R5 second queued", dataEmpty, 0);
    for (int i = 0; i < DW + 1; i++) doTick();
    check("R5 stop of first", txd, 1);
    doTick();
    check("R5 no gap start", txd, 0);
    check("R5 no done between", txDone, 0);
    check("R5 second transferred", dataEmpty, 1);
    for (int i = 0; i < DW; i++) begin
      doTick();
      check("R5 second data", txd, int'(DW'(3) >> i) & 1);
    end
    doTick();
    // end tick with a simultaneous acknowledge: set wins (R6)
    @(negedge clk) begin tick = 1; irqAck = 1; end
    @(negedge clk) begin tick = 0; irqAck = 0; end
    check("R6 set wins over ack", txDone, 1);
    check("R7 irqDone off when enable off", irqDone, 0);
    clearDone(1'b0);
    check("R6 doneClr clears", txDone, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule